// File: doc/BRIEF.md
# Inclusive Shared-Cache Victim Selector with Recall

This block holds the per-way state of one set of an inclusive shared cache: a valid bit, a tag, a sharer vector with one bit per private cache, and an age counter per way. A request from a private cache is looked up against the set. On a hit, the requester's sharer bit is set. On a miss, a victim way is chosen and the new block is placed in it.

Victim choice goes in this order: an invalid way first, then the least recently used way with an empty sharer vector, and only then the least recently used shared way. If the victim still has sharers, the block does not place the new block at once. It sends a recall to every recorded sharer and holds `busy_o` high until each of those caches has acknowledged. Only then is the way reused, which keeps the cache inclusive. A sharer bit means the private cache may hold the block, because clean copies can be dropped silently. For that reason, a recall to a cache that no longer holds the line is still acknowledged. An explicit eviction notice from a private cache clears that cache's bit for the named block.

Top module: `incl_victim_sel`

## Requirements
- R1: After reset every way is invalid, `busy_o` is low and no request hits.
- R2: A request whose tag matches a valid way drives `hit_o` high and `hit_way_o` to that way in the same cycle, and sets the requester's sharer bit in that way.
- R3: A missing request, while any way is invalid, fills the lowest-index invalid way in the same cycle (`fill_o`, `fill_way_o`). The new sharer vector holds only the requester.
- R4: When no way is invalid, a valid way with an empty sharer vector is always chosen over any shared way. Among such ways the least recently used is taken, and the fill happens in the same cycle without `busy_o`.
- R5: When every way is valid and shared, the least recently used way is chosen. No fill happens in that cycle; a recall starts instead.
- R6: From the cycle after a recall starts, `busy_o` is high, `recall_mask_o` shows the sharers still to acknowledge (bit i = private cache i), and `recall_tag_o` shows the victim's tag.
- R7: `busy_o` stays high until every recalled sharer has acknowledged on `recall_ack_i` (bit i = cache i). Acks for caches not pending are ignored. In the cycle the last pending ack arrives, `fill_o` is high with the victim way. `busy_o` is low in the next cycle.
- R8: While `busy_o` is high, requests are ignored: no hit, no fill, no state change.
- R9: An eviction notice clears only the notifying cache's sharer bit, and only in a valid way whose tag matches. A notice whose tag matches no way has no effect.
- R10: Recency is updated on every hit and every fill; the touched way becomes most recently used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request from a private cache |
| req_tag_i | input | TAG_W | Requested block tag |
| req_src_i | input | SRC_W | Index of requesting private cache |
| evict_valid_i | input | 1 | Explicit eviction notice |
| evict_tag_i | input | TAG_W | Tag of evicted block |
| evict_src_i | input | SRC_W | Index of notifying private cache |
| recall_ack_i | input | NUM_PRIV | Recall acknowledgments, one bit per cache |
| hit_o | output | 1 | Request hit |
| hit_way_o | output | WAY_W | Way that hit |
| fill_o | output | 1 | New block placed this cycle |
| fill_way_o | output | WAY_W | Way being filled |
| busy_o | output | 1 | Recall in progress; requester must stall |
| recall_mask_o | output | NUM_PRIV | Sharers still to acknowledge |
| recall_tag_o | output | TAG_W | Tag of the block being recalled |

## Verification
The assertions check on every cycle that at most one way matches a tag, and that an invalid way is preferred whenever one exists. They also check that an immediate fill never lands on a shared way, that `busy_o` cannot drop while acks are outstanding, and that every end of a recall coincides with a fill. Only the directed scenarios can show which way the recency order actually selects. The same holds for whether notices with foreign tags leave the sharer vectors untouched, whether ignored requests during a recall leave the set unchanged, and whether the recall mask and tag match the victim's recorded sharers.

// File: rtl/ivs_pkg.sv
package ivs_pkg;
  typedef enum logic {ST_IDLE, ST_RECALL} seq_state_e;
endpackage

// File: rtl/ivs_age_tracker.sv
module ivs_age_tracker #(
  parameter int NUM_WAYS = 8,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int AGE_W = $clog2(NUM_WAYS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            touch_i,
  input  logic [WAY_W-1:0]                way_i,
  output logic [NUM_WAYS-1:0][AGE_W-1:0]  age_o
);
  logic [NUM_WAYS-1:0][AGE_W-1:0] age_q;
  logic [AGE_W-1:0] ref_age;

  assign ref_age = age_q[way_i];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_age
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) age_q[w] <= AGE_W'(w);
      else if (touch_i) begin
        if (WAY_W'(w) == way_i)   age_q[w] <= '0;
        else if (age_q[w] < ref_age) age_q[w] <= age_q[w] + 1'b1;
      end
    end
  end

  assign age_o = age_q;

  // R10
  touched_mru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> age_q[$past(way_i)] == '0);
endmodule

// File: rtl/ivs_victim_pick.sv
module ivs_victim_pick #(
  parameter int NUM_WAYS = 8,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int AGE_W = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0]             valid_i,
  input  logic [NUM_WAYS-1:0]             shared_i,
  input  logic [NUM_WAYS-1:0][AGE_W-1:0]  age_i,
  output logic [WAY_W-1:0]                way_o,
  output logic                            shared_o
);
  logic             have_inv, have_free;
  logic [WAY_W-1:0] inv_way, free_way, any_way;
  logic [AGE_W-1:0] free_age, any_age;

  always_comb begin
    have_inv = 1'b0; have_free = 1'b0;
    inv_way = '0; free_way = '0; any_way = '0;
    free_age = '0; any_age = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) begin
        have_inv = 1'b1;
        inv_way  = WAY_W'(w);
      end
    end
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (valid_i[w] && !shared_i[w] && (!have_free || age_i[w] > free_age)) begin
        have_free = 1'b1;
        free_way  = WAY_W'(w);
        free_age  = age_i[w];
      end
      if (w == 0 || age_i[w] > any_age) begin
        any_way = WAY_W'(w);
        any_age = age_i[w];
      end
    end
    if (have_inv)       way_o = inv_way;
    else if (have_free) way_o = free_way;
    else                way_o = any_way;
    shared_o = valid_i[way_o] && shared_i[way_o];
  end

  // R3
  invalid_first_chk: assert final (!(|(~valid_i)) || !valid_i[way_o]);
  // R4
  unshared_first_chk: assert final (!(|(valid_i & ~shared_i)) || (|(~valid_i)) || !shared_o);
endmodule

// File: rtl/ivs_recall_seq.sv
module ivs_recall_seq
  import ivs_pkg::*;
#(
  parameter int NUM_PRIV = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [NUM_PRIV-1:0] start_mask_i,
  input  logic [NUM_PRIV-1:0] ack_i,
  output logic                busy_o,
  output logic [NUM_PRIV-1:0] pending_o,
  output logic                done_o
);
  seq_state_e          state_q;
  logic [NUM_PRIV-1:0] pend_q, pend_nxt;

  assign pend_nxt = pend_q & ~ack_i;
  assign busy_o   = (state_q == ST_RECALL);
  assign done_o   = busy_o && (pend_nxt == '0);
  assign pending_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
    end else if (state_q == ST_IDLE) begin
      if (start_i) begin
        state_q <= ST_RECALL;
        pend_q  <= start_mask_i;
      end
    end else begin
      pend_q <= pend_nxt;
      if (pend_nxt == '0) state_q <= ST_IDLE;
    end
  end

  // R7
  hold_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && ((pend_q & ~ack_i) != '0) |=> busy_o);
  // R7
  no_new_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (pend_q & ~$past(pend_q)) == '0);
endmodule

// File: rtl/incl_victim_sel.sv
module incl_victim_sel #(
  parameter int NUM_WAYS = 8,
  parameter int NUM_PRIV = 4,
  parameter int TAG_W    = 16,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SRC_W = $clog2(NUM_PRIV),
  localparam int AGE_W = $clog2(NUM_WAYS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [TAG_W-1:0]    req_tag_i,
  input  logic [SRC_W-1:0]    req_src_i,
  input  logic                evict_valid_i,
  input  logic [TAG_W-1:0]    evict_tag_i,
  input  logic [SRC_W-1:0]    evict_src_i,
  input  logic [NUM_PRIV-1:0] recall_ack_i,
  output logic                hit_o,
  output logic [WAY_W-1:0]    hit_way_o,
  output logic                fill_o,
  output logic [WAY_W-1:0]    fill_way_o,
  output logic                busy_o,
  output logic [NUM_PRIV-1:0] recall_mask_o,
  output logic [TAG_W-1:0]    recall_tag_o
);
  logic [NUM_WAYS-1:0]                valid_q;
  logic [NUM_WAYS-1:0][TAG_W-1:0]     tag_q;
  logic [NUM_WAYS-1:0][NUM_PRIV-1:0]  shr_q;
  logic [NUM_WAYS-1:0]                hit_vec, shared_vec;
  logic [NUM_WAYS-1:0][AGE_W-1:0]     age;

  logic [WAY_W-1:0] vic_way, rc_way_q;
  logic             vic_shared, idle, miss;
  logic             imm_fill, rc_start, rc_done;
  logic [TAG_W-1:0] rc_new_tag_q, fill_tag;
  logic [SRC_W-1:0] rc_new_src_q, fill_src;
  logic             touch;
  logic [WAY_W-1:0] touch_way;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign hit_vec[w]    = valid_q[w] && (tag_q[w] == req_tag_i);
    assign shared_vec[w] = |shr_q[w];
  end

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (hit_vec[w]) hit_way_o = WAY_W'(w);
  end

  assign idle     = !busy_o;
  assign hit_o    = req_valid_i && idle && (|hit_vec);
  assign miss     = req_valid_i && idle && !(|hit_vec);
  assign imm_fill = miss && !vic_shared;
  assign rc_start = miss && vic_shared;

  assign fill_o     = imm_fill || rc_done;
  assign fill_way_o = rc_done ? rc_way_q : vic_way;
  assign fill_tag   = rc_done ? rc_new_tag_q : req_tag_i;
  assign fill_src   = rc_done ? rc_new_src_q : req_src_i;

  assign touch     = hit_o || fill_o;
  assign touch_way = hit_o ? hit_way_o : fill_way_o;
  assign recall_tag_o = tag_q[rc_way_q];

  ivs_victim_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
    .valid_i (valid_q),
    .shared_i(shared_vec),
    .age_i   (age),
    .way_o   (vic_way),
    .shared_o(vic_shared)
  );

  ivs_age_tracker #(.NUM_WAYS(NUM_WAYS)) u_age (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .touch_i(touch),
    .way_i  (touch_way),
    .age_o  (age)
  );

  ivs_recall_seq #(.NUM_PRIV(NUM_PRIV)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (rc_start),
    .start_mask_i(shr_q[vic_way]),
    .ack_i       (recall_ack_i),
    .busy_o      (busy_o),
    .pending_o   (recall_mask_o),
    .done_o      (rc_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rc_way_q     <= '0;
      rc_new_tag_q <= '0;
      rc_new_src_q <= '0;
    end else if (rc_start) begin
      rc_way_q     <= vic_way;
      rc_new_tag_q <= req_tag_i;
      rc_new_src_q <= req_src_i;
    end
  end

  // evict clear, then hit set, then fill overwrite
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
      shr_q   <= '0;
    end else begin
      if (evict_valid_i)
        for (int w = 0; w < NUM_WAYS; w++)
          if (valid_q[w] && tag_q[w] == evict_tag_i) shr_q[w][evict_src_i] <= 1'b0;
      if (hit_o) shr_q[hit_way_o][req_src_i] <= 1'b1;
      if (fill_o) begin
        valid_q[fill_way_o] <= 1'b1;
        tag_q[fill_way_o]   <= fill_tag;
        shr_q[fill_way_o]   <= NUM_PRIV'(1) << fill_src;
      end
    end
  end

  // R2
  single_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
  // R4
  imm_fill_unshared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o && !busy_o |-> !(valid_q[fill_way_o] && (|shr_q[fill_way_o])));
  // R7
  busy_end_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(fill_o));
  // R8
  busy_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !hit_o);
endmodule

// File: tb/sim_incl_victim_sel.sv
module sim_incl_victim_sel;
  localparam int NW = 8, NP = 4, TW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_v = 0, ev_v = 0;
  logic [TW-1:0] req_tag = '0, ev_tag = '0;
  logic [1:0] req_src = '0, ev_src = '0;
  logic [NP-1:0] ack = '0;
  logic hit, fill, busy;
  logic [2:0] hit_way, fill_way;
  logic [NP-1:0] rmask;
  logic [TW-1:0] rtag;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  incl_victim_sel u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_v), .req_tag_i(req_tag), .req_src_i(req_src),
    .evict_valid_i(ev_v), .evict_tag_i(ev_tag), .evict_src_i(ev_src),
    .recall_ack_i(ack),
    .hit_o(hit), .hit_way_o(hit_way), .fill_o(fill), .fill_way_o(fill_way),
    .busy_o(busy), .recall_mask_o(rmask), .recall_tag_o(rtag)
  );

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; req_v = 0; ev_v = 0; ack = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // drive a request for one cycle, sample combinational outputs mid-cycle
  task automatic req(input logic [TW-1:0] t, input logic [1:0] s,
                     output logic h, output logic [2:0] hw,
                     output logic f, output logic [2:0] fw);
    req_v = 1; req_tag = t; req_src = s;
    #5; h = hit; hw = hit_way; f = fill; fw = fill_way;
    @(negedge clk); req_v = 0;
  endtask

  task automatic evict(input logic [TW-1:0] t, input logic [1:0] s);
    ev_v = 1; ev_tag = t; ev_src = s;
    @(negedge clk); ev_v = 0;
  endtask

  task automatic t_reset();
    logic h, f; logic [2:0] hw, fw;
    do_reset();
    chk("R1 busy", busy, 0);
    req_v = 1; req_tag = 16'h10; #5;
    chk("R1 hit", hit, 0);
    req_v = 0; @(negedge clk);
  endtask

  task automatic t_preference();
    logic h, f; logic [2:0] hw, fw;
    do_reset();
    for (int i = 0; i < 8; i++) begin
      req(16'h10 + 16'(i), 2'd0, h, hw, f, fw);
      chk("R3 fill", f, 1);
      chk("R3 fill way", fw, i);
    end
    req(16'h13, 2'd2, h, hw, f, fw);
    chk("R2 hit", h, 1);
    chk("R2 hit way", hw, 3);
    evict(16'h12, 2'd0);
    evict(16'h15, 2'd0);
    req(16'h20, 2'd1, h, hw, f, fw);
    chk("R4 immediate fill", f, 1);
    chk("R4 LRU unshared way", fw, 2);
    chk("R4 no busy", busy, 0);
    req(16'h21, 2'd1, h, hw, f, fw);
    chk("R4 second unshared way", fw, 5);
    evict(16'h90, 2'd0);  // R9 foreign tag must not clear way 0
    req(16'h22, 2'd1, h, hw, f, fw);
    chk("R5 no fill on shared victim", f, 0);
    chk("R6 busy", busy, 1);
    chk("R9 R6 recall mask", rmask, 4'b0001);
    chk("R6 recall tag LRU way0", rtag, 16'h10);
    req(16'h13, 2'd3, h, hw, f, fw);
    chk("R8 hit ignored", h, 0);
    chk("R8 fill ignored", f, 0);
    req(16'h30, 2'd3, h, hw, f, fw);
    chk("R8 miss ignored", f, 0);
    chk("R7 still busy", busy, 1);
    ack = 4'b0001; #5;
    chk("R7 fill on last ack", fill, 1);
    chk("R7 fill way", fill_way, 0);
    @(negedge clk); ack = '0;
    chk("R7 busy drops", busy, 0);
    req(16'h22, 2'd1, h, hw, f, fw);
    chk("R7 new block present", h, 1);
    chk("R7 new block way", hw, 0);
    req(16'h30, 2'd3, h, hw, f, fw);
    chk("R8 ignored miss left no block", h, 0);
  endtask

  task automatic t_multi_recall();
    logic h, f; logic [2:0] hw, fw;
    do_reset();
    req(16'h40, 2'd0, h, hw, f, fw);
    req(16'h40, 2'd2, h, hw, f, fw);
    req(16'h40, 2'd3, h, hw, f, fw);
    for (int i = 1; i < 8; i++) req(16'h40 + 16'(i), 2'd1, h, hw, f, fw);
    req(16'h50, 2'd2, h, hw, f, fw);
    chk("R10 R5 no fill", f, 0);
    chk("R6 multi mask", rmask, 4'b1101);
    chk("R6 multi tag", rtag, 16'h40);
    ack = 4'b0010; #5;
    chk("R7 foreign ack no fill", fill, 0);
    @(negedge clk);
    chk("R7 foreign ack ignored", rmask, 4'b1101);
    ack = 4'b1001; #5;
    chk("R7 partial ack no fill", fill, 0);
    @(negedge clk);
    chk("R7 partial mask", rmask, 4'b0100);
    chk("R7 busy partial", busy, 1);
    ack = 4'b0100; #5;
    chk("R7 final fill", fill, 1);
    chk("R7 final way", fill_way, 0);
    @(negedge clk); ack = '0;
    chk("R7 idle", busy, 0);
    req(16'h50, 2'd3, h, hw, f, fw);
    chk("R2 hit after recall", h, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_preference();
        t_multi_recall();
      end
      begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule